// File: doc/BRIEF.md
# Nibble-Pairing Register Datapath

This block is the register cluster of a lookup-table ALU for 8-bit data. Nothing in it adds or compares. An operation works on 4-bit pieces instead. The two operands are split into nibble pairs. Each pair forms an 8-bit index into a 256-entry table held in external memory. The per-nibble results are then joined back into one byte.

The cluster holds three registers and one optional register:
- A temporary register, which the bus loads.
- A low-index register and a high-index register. A single paired-load strobe fills both of them from the temporary register and the bus.
- A merge register (optional). It places a looked-up nibble above the temporary register's low nibble.

The temporary register always drives its output. That output feeds the condition flags (half carry, sign, zero and non-zero) and serves as the high program-counter byte for long jumps. The two index registers are offered to the memory system as low address sources.

An XOR runs in four steps:
1. Load the first operand into the temporary register.
2. Paired-load the second operand.
3. Load the temporary register with the lookup at the low index.
4. Merge with the lookup at the high index.

An ADD follows the same steps. For the high-nibble lookup, the control logic selects a table variant that adds one when the half-carry flag is set.

A parameter removes the merge register. In that variant the merge write lands in the low-index register, which then holds the result.

Top module: `nibble_pair_regs`

## Requirements
- R1: A synchronous active-high reset clears the temporary register, both index registers and the merge register to 0x00 on the next rising edge.
- R2: When `we_tmp` is high, the temporary register takes `bus_in` at the clock edge. Otherwise it keeps its value.
- R3: When `we_pair` is high, both index registers load at the same edge. The low index takes {T[3:0], bus[3:0]} and the high index takes {T[7:4], bus[7:4]}. T is the temporary register's value before that edge, even if `we_tmp` is high in the same cycle.
- R4: With the merge register present, `we_merge` loads it with {bus[7:4], T[3:0]}.
- R5: Each flag follows the temporary register combinationally:
  - `flag_hc` is T bit 4.
  - `flag_sign` is T bit 7.
  - `flag_nz` is the OR of all T bits.
  - `flag_z` is its inverse.
- R6: `tmp_q` always shows the temporary register, for use as the long-jump page byte.
- R7: With the merge register absent (`HAS_MERGE`=0), `we_merge` writes {bus[7:4], T[3:0]} into the low-index register and wins over a simultaneous `we_pair` for that register. `mrg_q` then reads 0x00.
- R8: Without a strobe, each index register holds its value.
- R9: The four-step XOR and ADD sequences give a^b and (a+b) mod 256 for the operand pairs swept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | DW | Data bus value |
| we_tmp | input | 1 | Load temporary register from bus |
| we_pair | input | 1 | Paired nibble load of both index registers |
| we_merge | input | 1 | Merge write |
| tmp_q | output | DW | Temporary register (also long-jump page byte) |
| idx_lo_q | output | DW | Low-nibble index register |
| idx_hi_q | output | DW | High-nibble index register |
| mrg_q | output | DW | Merge register (0 when absent) |
| flag_hc | output | 1 | Half carry, T bit 4 |
| flag_sign | output | 1 | Sign, T bit 7 |
| flag_nz | output | 1 | T non-zero |
| flag_z | output | 1 | T zero |

## Verification
The bench loads the temporary register and pairs in the same cycle. A design that used the new value of T would build indices from the wrong operand.

Vectors with asymmetric nibbles (0x5A with 0xC3) expose swapped or transposed nibble placement in the index and merge words. An XOR-only check could hide such a swap, because XOR is symmetric.

The ADD sweep includes every low-nibble carry. A half-carry flag taken from the wrong bit would produce sums off by sixteen.

In the variant without the merge register, a simultaneous paired load and merge must leave the merge result in the low index. A wrong priority shows up there as the paired value.

// File: rtl/nibble_pair_regs.sv
module nibble_pair_regs #(
  parameter int DW        = 8,
  parameter bit HAS_MERGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_in,
  input  logic          we_tmp,
  input  logic          we_pair,
  input  logic          we_merge,
  output logic [DW-1:0] tmp_q,
  output logic [DW-1:0] idx_lo_q,
  output logic [DW-1:0] idx_hi_q,
  output logic [DW-1:0] mrg_q,
  output logic          flag_hc,
  output logic          flag_sign,
  output logic          flag_nz,
  output logic          flag_z
);
  localparam int NW = DW / 2;

  logic [DW-1:0] tmp_r, lo_r, hi_r;
  logic [DW-1:0] pair_lo, pair_hi, merged;

  assign pair_lo = {tmp_r[NW-1:0], bus_in[NW-1:0]};
  assign pair_hi = {tmp_r[DW-1:NW], bus_in[DW-1:NW]};
  assign merged  = {bus_in[DW-1:NW], tmp_r[NW-1:0]};

  always_ff @(posedge clk) begin
    if (rst)         tmp_r <= '0;
    else if (we_tmp) tmp_r <= bus_in;
  end

  always_ff @(posedge clk) begin
    if (rst)          hi_r <= '0;
    else if (we_pair) hi_r <= pair_hi;
  end

  generate
    if (HAS_MERGE) begin : g_mrg
      logic [DW-1:0] mrg_r;
      always_ff @(posedge clk) begin
        if (rst)           mrg_r <= '0;
        else if (we_merge) mrg_r <= merged;
      end
      always_ff @(posedge clk) begin
        if (rst)          lo_r <= '0;
        else if (we_pair) lo_r <= pair_lo;
      end
      assign mrg_q = mrg_r;
    end else begin : g_nomrg
      always_ff @(posedge clk) begin
        if (rst)           lo_r <= '0;
        else if (we_merge) lo_r <= merged;
        else if (we_pair)  lo_r <= pair_lo;
      end
      assign mrg_q = '0;
    end
  endgenerate

  assign tmp_q     = tmp_r;
  assign idx_lo_q  = lo_r;
  assign idx_hi_q  = hi_r;
  assign flag_hc   = tmp_r[NW];
  assign flag_sign = tmp_r[DW-1];
  assign flag_nz   = |tmp_r;
  assign flag_z    = ~flag_nz;
endmodule

module nibble_pair_regs_chk #(
  parameter int DW        = 8,
  parameter bit HAS_MERGE = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] bus_in,
  input logic          we_tmp,
  input logic          we_pair,
  input logic          we_merge,
  input logic [DW-1:0] tmp_q,
  input logic [DW-1:0] idx_lo_q,
  input logic [DW-1:0] idx_hi_q,
  input logic [DW-1:0] mrg_q,
  input logic          flag_hc,
  input logic          flag_sign,
  input logic          flag_nz,
  input logic          flag_z
);
  localparam int NW = DW / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tmp_q == '0 && idx_lo_q == '0 && idx_hi_q == '0 && mrg_q == '0));

  assert_tmp_load_R2: assert property (@(posedge clk) disable iff (rst)
    we_tmp |=> tmp_q == $past(bus_in));

  assert_tmp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we_tmp |=> $stable(tmp_q));

  assert_pair_hi_R3: assert property (@(posedge clk) disable iff (rst)
    we_pair |=> idx_hi_q == {$past(tmp_q[DW-1:NW]), $past(bus_in[DW-1:NW])});

  assert_sign_follows_R5: assert property (@(posedge clk) disable iff (rst)
    we_tmp |=> (flag_sign == $past(bus_in[DW-1]) && flag_hc == $past(bus_in[NW])));

  assert_zero_pair_R5: assert property (@(posedge clk) disable iff (rst)
    flag_z != flag_nz);

  assert_hold_hi_R8: assert property (@(posedge clk) disable iff (rst)
    !we_pair |=> $stable(idx_hi_q));

  generate
    if (HAS_MERGE) begin : g_a
      assert_merge_R4: assert property (@(posedge clk) disable iff (rst)
        we_merge |=> mrg_q == {$past(bus_in[DW-1:NW]), $past(tmp_q[NW-1:0])});
      assert_pair_lo_R3: assert property (@(posedge clk) disable iff (rst)
        we_pair |=> idx_lo_q == {$past(tmp_q[NW-1:0]), $past(bus_in[NW-1:0])});
    end else begin : g_b
      assert_merge_lo_R7: assert property (@(posedge clk) disable iff (rst)
        we_merge |=> idx_lo_q == {$past(bus_in[DW-1:NW]), $past(tmp_q[NW-1:0])});
      assert_no_mrg_R7: assert property (@(posedge clk) mrg_q == '0);
      assert_hold_lo_R8: assert property (@(posedge clk) disable iff (rst)
        (!we_pair && !we_merge) |=> $stable(idx_lo_q));
    end
  endgenerate
endmodule

bind nibble_pair_regs nibble_pair_regs_chk #(.DW(DW), .HAS_MERGE(HAS_MERGE)) u_chk (
  .clk(clk), .rst(rst), .bus_in(bus_in), .we_tmp(we_tmp), .we_pair(we_pair),
  .we_merge(we_merge), .tmp_q(tmp_q), .idx_lo_q(idx_lo_q), .idx_hi_q(idx_hi_q),
  .mrg_q(mrg_q), .flag_hc(flag_hc), .flag_sign(flag_sign), .flag_nz(flag_nz),
  .flag_z(flag_z)
);

// File: tb/nibble_pair_regs_tb.sv
module nibble_pair_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_in = '0;
  logic we_tmp = 1'b0, we_pair = 1'b0, we_merge = 1'b0;
  logic [7:0] tmp_q, lo_q, hi_q, mrg_q;
  logic hc, sg, nz, zz;
  logic [7:0] ntmp, nlo, nhi, nmrg;
  logic nhc, nsg, nnz, nzz;
  int tests = 0, fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nibble_pair_regs #(.DW(8), .HAS_MERGE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .we_tmp(we_tmp), .we_pair(we_pair),
    .we_merge(we_merge), .tmp_q(tmp_q), .idx_lo_q(lo_q), .idx_hi_q(hi_q),
    .mrg_q(mrg_q), .flag_hc(hc), .flag_sign(sg), .flag_nz(nz), .flag_z(zz));

  nibble_pair_regs #(.DW(8), .HAS_MERGE(1'b0)) u_dut_nm (
    .clk(clk), .rst(rst), .bus_in(bus_in), .we_tmp(we_tmp), .we_pair(we_pair),
    .we_merge(we_merge), .tmp_q(ntmp), .idx_lo_q(nlo), .idx_hi_q(nhi),
    .mrg_q(nmrg), .flag_hc(nhc), .flag_sign(nsg), .flag_nz(nnz), .flag_z(nzz));

  // {T, bus, expected low index, expected high index, expected merge}
  localparam logic [39:0] VEC [0:5] = '{
    40'hA1_B2_12_AB_B1,
    40'h00_FF_0F_0F_F0,
    40'hFF_00_F0_F0_0F,
    40'h5A_C3_A3_5C_CA,
    40'h80_01_01_80_00,
    40'h1E_E1_E1_1E_EE
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic p, input logic m, input logic [7:0] b);
    we_tmp = t; we_pair = p; we_merge = m; bus_in = b;
    @(posedge clk); #2;
    we_tmp = 0; we_pair = 0; we_merge = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] s;
    logic [3:0] r;
    repeat (2) @(posedge clk); #2;
    rst = 1'b0;
    // R1 reset state
    chk("R1 tmp", tmp_q, 8'h00); chk("R1 lo", lo_q, 8'h00);
    chk("R1 hi", hi_q, 8'h00);   chk("R1 mrg", mrg_q, 8'h00);
    // R5 flags at zero
    chk("R5 z/nz/hc/sign", {4'b0, zz, nz, hc, sg}, 8'b0000_1000);

    // vector table: R3 paired load, R4 merge, R7 priority without merge register
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, VEC[i][39:32]);
      step(0, 1, 1, VEC[i][31:24]);
      chk("R3 lo", lo_q, VEC[i][23:16]);
      chk("R3 hi", hi_q, VEC[i][15:8]);
      chk("R4 merge", mrg_q, VEC[i][7:0]);
      chk("R7 merge wins in lo", nlo, VEC[i][7:0]);
      chk("R7 hi still paired", nhi, VEC[i][15:8]);
      chk("R7 mrg absent", nmrg, 8'h00);
    end

    // R6 / R2 / R5 flags
    step(1, 0, 0, 8'h10);
    chk("R6 tmp out", tmp_q, 8'h10);
    chk("R5 hc", {7'b0, hc}, 8'h01);
    chk("R5 nz", {6'b0, nz, zz}, 8'b10);
    step(1, 0, 0, 8'h80);
    chk("R5 sign", {6'b0, sg, hc}, 8'b10);
    step(0, 0, 0, 8'h3C);
    chk("R2 hold", tmp_q, 8'h80);

    // R3 uses old T when T is written in the same cycle
    step(1, 0, 0, 8'hA1);
    step(1, 1, 0, 8'hB2);
    chk("R3 old T lo", lo_q, 8'h12);
    chk("R3 old T hi", hi_q, 8'hAB);
    chk("R2 T loaded", tmp_q, 8'hB2);

    // R8 hold with no strobe
    step(0, 0, 0, 8'hFF);
    chk("R8 lo hold", lo_q, 8'h12);
    chk("R8 hi hold", hi_q, 8'hAB);
    chk("R8 nm lo hold", nlo, 8'h12);

    // R1 reset mid-run
    rst = 1'b1; @(posedge clk); #2; rst = 1'b0;
    chk("R1 reset again", tmp_q | lo_q | hi_q | mrg_q, 8'h00);

    // R9 XOR and ADD sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        step(1, 0, 0, 8'(a));
        step(0, 1, 0, 8'(b));
        step(1, 0, 0, {4'h0, lo_q[7:4] ^ lo_q[3:0]});
        r = hi_q[7:4] ^ hi_q[3:0];
        step(0, 0, 1, {r, 4'h0});
        chk("R9 xor", mrg_q, 8'(a ^ b));
        chk("R9 xor nm", nlo, 8'(a ^ b));
        step(1, 0, 0, 8'(a));
        step(0, 1, 0, 8'(b));
        s = {1'b0, lo_q[7:4]} + {1'b0, lo_q[3:0]};
        step(1, 0, 0, {3'b0, s});
        chk("R5 hc after nibble add", {7'b0, hc}, {7'b0, ((a % 16) + (b % 16)) > 15});
        r = hi_q[7:4] + hi_q[3:0] + {3'b0, hc};
        step(0, 0, 1, {r, 4'h0});
        chk("R9 add", mrg_q, 8'(a + b));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule